// File: doc/BRIEF.md
# Bloom-Filter Transaction Conflict Signature Unit

This block keeps the read set and the write set of one running transaction as two hashed bit-vector signatures. Every core access marks bits in one of the two signatures. Nothing in the block depends on the cache or on the coherence protocol. When another transaction commits, it broadcasts its write signature. The block intersects that signature with both local signatures as whole vectors, and it raises a conflict when the intersection may be non-empty.

Each signature is split into `NBANK` banks of `2**IDX_W` bits each. An address marks exactly one bit per bank, and each bank uses a different hash. An intersection counts only when every bank shares at least one bit. The filter is inexact, so an unrelated set of addresses can alias and produce a false conflict. A true conflict is always reported.

The core pulses a clear strobe when the transaction commits or aborts. The local write signature is driven out so that it can be broadcast at this transaction's own commit. With the default parameters each signature is 2048 bits wide, in four banks of 512 bits.

Top module: `sig_unit`

## Requirements
- R1: While reset is low, and after it is released, both signatures are all zero, `loc_wsig` is zero and `conflict` is 0. Reset is applied asynchronously and released synchronously, two clock edges after `rst_n` rises.
- R2: A write insert (`ins_valid`=1, `ins_is_wr`=1) sets one bit in each bank of the write signature. This is visible on `loc_wsig` after the next edge.
  - Bank k occupies bits `[k*2**IDX_W +: 2**IDX_W]`.
  - The bit index within bank k is computed as follows. Split `ins_addr`, zero-padded, into `IDX_W`-bit chunks. Rotate chunk 0 left by `k mod IDX_W`. XOR the result with all the other chunks.
- R3: A read insert (`ins_is_wr`=0) changes only the read signature. `loc_wsig` stays unchanged.
- R4: `conflict` is registered. One edge after `rmt_valid` is sampled high, it is 1 exactly when the remote signature intersects the read signature in every bank, or intersects the write signature in every bank. Both use the bank layout of R2.
- R5: If `rmt_valid` was low at the previous edge, `conflict` is 0.
- R6: A remote signature that shares bits with a local signature in only some of the banks raises no conflict.
- R7: A clear strobe zeroes both signatures at the next edge. A clear takes priority over an insert in the same cycle.
- R8: Suppose every bank of the remote signature is non-empty and the remote signature is fully contained in a local signature. Then a conflict is always raised, so no true conflict is missed.
- R9: Addresses inserted one after another can together cover another address's bits and raise a false conflict for an address that was never inserted.
- R10: A check in the same cycle as an insert or a clear is evaluated against the signatures as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert an address this cycle |
| ins_is_wr | input | 1 | 1 = write access, 0 = read access |
| ins_addr | input | ADDR_W | Line address to insert |
| clr | input | 1 | Clear both signatures (commit or abort) |
| rmt_valid | input | 1 | Remote commit signature present |
| rmt_sig | input | NBANK*2**IDX_W | Remote write signature |
| loc_wsig | output | NBANK*2**IDX_W | Local write signature for broadcast |
| conflict | output | 1 | Registered conflict flag |

## Verification
The bench builds the unit with `ADDR_W`=8, `IDX_W`=4 and four banks, which gives a 64-bit signature made of two 4-bit address chunks. With banks this narrow, the hash indices can be worked out by hand.

This puts bank aliasing within reach. Two read inserts, 0x55 and 0x5A, together cover every bank bit of the never-inserted address 0x00, which produces a false conflict. Address 0x55 alone covers only banks 0 and 2, which exercises the partial-overlap case.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/sig_hash.sv
// One bank's index hash: the low chunk rotated by the bank number, XOR-folded
// with every higher chunk of the address.
module sig_hash #(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 9,
  parameter int ROT    = 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;
  localparam int RS     = ROT % IDX_W;

  logic [PAD_W-1:0]   padded;
  logic [2*IDX_W-1:0] dbl;

  assign padded = PAD_W'(addr);
  assign dbl    = {padded[IDX_W-1:0], padded[IDX_W-1:0]};

  always_comb begin
    idx = dbl[2*IDX_W-1-RS -: IDX_W];
    for (int c = 1; c < NCHUNK; c++) begin
      idx = idx ^ padded[c*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/sig_bank.sv
// One bank of the read and write signatures, with its intersection test.
module sig_bank
  import sig_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_en,
  input  acc_kind_e           ins_kind,
  input  logic                clr,
  input  logic [IDX_W-1:0]    idx,
  input  logic [(1<<IDX_W)-1:0] rmt_slice,
  output logic                rd_hit,
  output logic                wr_hit,
  output logic [(1<<IDX_W)-1:0] wr_bits
);
  localparam int BANK_BITS = 1 << IDX_W;

  logic [BANK_BITS-1:0] rd_q, rd_d, wr_q, wr_d, mark;
  logic                 upd_en;

  assign mark   = BANK_BITS'(1) << idx;
  assign upd_en = clr | ins_en;

  always_comb begin
    rd_d = rd_q;
    wr_d = wr_q;
    if (clr) begin
      rd_d = '0;
      wr_d = '0;
    end else if (ins_en) begin
      if (ins_kind == ACC_WR) wr_d = wr_q | mark;
      else                    rd_d = rd_q | mark;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else if (upd_en) begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  assign rd_hit  = |(rd_q & rmt_slice);
  assign wr_hit  = |(wr_q & rmt_slice);
  assign wr_bits = wr_q;
endmodule

// File: rtl/sig_unit.sv
module sig_unit
  import sig_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 9,
  parameter int NBANK  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ins_valid,
  input  logic                            ins_is_wr,
  input  logic [ADDR_W-1:0]               ins_addr,
  input  logic                            clr,
  input  logic                            rmt_valid,
  input  logic [NBANK*(1<<IDX_W)-1:0]     rmt_sig,
  output logic [NBANK*(1<<IDX_W)-1:0]     loc_wsig,
  output logic                            conflict
);
  localparam int BANK_BITS = 1 << IDX_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  acc_kind_e        kind;
  logic [NBANK-1:0] rd_hit, wr_hit;
  logic             conflict_d, conflict_q;

  assign kind = ins_is_wr ? ACC_WR : ACC_RD;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    logic [IDX_W-1:0] idx;
    sig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROT(k)) u_hash (
      .addr (ins_addr),
      .idx  (idx)
    );
    sig_bank #(.IDX_W(IDX_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .ins_en    (ins_valid),
      .ins_kind  (kind),
      .clr       (clr),
      .idx       (idx),
      .rmt_slice (rmt_sig[k*BANK_BITS +: BANK_BITS]),
      .rd_hit    (rd_hit[k]),
      .wr_hit    (wr_hit[k]),
      .wr_bits   (loc_wsig[k*BANK_BITS +: BANK_BITS])
    );
  end

  assign conflict_d = rmt_valid & ((&rd_hit) | (&wr_hit));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) conflict_q <= 1'b0;
    else            conflict_q <= conflict_d;
  end

  assign conflict = conflict_q;
endmodule

// File: rtl/sig_unit_chk.sv
module sig_unit_chk #(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 9,
  parameter int NBANK  = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ins_valid,
  input logic                        ins_is_wr,
  input logic [ADDR_W-1:0]           ins_addr,
  input logic                        clr,
  input logic                        rmt_valid,
  input logic [NBANK*(1<<IDX_W)-1:0] rmt_sig,
  input logic [NBANK*(1<<IDX_W)-1:0] loc_wsig,
  input logic                        conflict
);
  localparam int BANK_BITS = 1 << IDX_W;

  logic all_banks_set;
  always_comb begin
    all_banks_set = 1'b1;
    for (int k = 0; k < NBANK; k++) begin
      if (rmt_sig[k*BANK_BITS +: BANK_BITS] == '0) all_banks_set = 1'b0;
    end
  end

  // R5: conflict only follows a presented remote signature
  assert_no_check_no_conflict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rmt_valid |=> !conflict);

  // R7: clear empties the write signature
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> loc_wsig == '0);

  // R3: without write insert or clear the write signature holds
  assert_wsig_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(ins_valid && ins_is_wr) |=> $stable(loc_wsig));

  // R2: a write insert keeps earlier bits and adds at most one bit per bank
  assert_wr_insert_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && ins_is_wr && !clr |=>
      ((loc_wsig & $past(loc_wsig)) == $past(loc_wsig)) &&
      ($countones(loc_wsig ^ $past(loc_wsig)) <= NBANK));

  // R8: a remote set contained in the local write set is always flagged
  assert_no_missed_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_valid && all_banks_set && ((rmt_sig & loc_wsig) == rmt_sig) |=> conflict);
endmodule

bind sig_unit sig_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NBANK(NBANK)) u_chk (.*);

// File: tb/sig_unit_test.sv
`timescale 1ns/1ps
module sig_unit_test;
  localparam int AW = 8;
  localparam int IW = 4;
  localparam int NB = 4;
  localparam int BB = 1 << IW;
  localparam int SW = NB * BB;

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_CLR = 2'd2, OP_CHK = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  8'h55, 8'h55, 4'd3},  // R3 read insert leaves loc_wsig
    '{OP_CHK, 8'h00, 8'h00, 4'd6},  // R6 banks 0,2 only: no conflict
    '{OP_RD,  8'h5A, 8'h5A, 4'd3},
    '{OP_CHK, 8'h00, 8'h00, 4'd9},  // R9 aliasing: false conflict
    '{OP_WR,  8'h35, 8'h35, 4'd2},  // R2
    '{OP_CHK, 8'h35, 8'h35, 4'd8},  // R8
    '{OP_CHK, 8'h35, 8'hE1, 4'd4},  // R4 union remote
    '{OP_CLR, 8'h00, 8'h00, 4'd7},  // R7
    '{OP_CHK, 8'h00, 8'h00, 4'd7},
    '{OP_WR,  8'h12, 8'h12, 4'd2},
    '{OP_WR,  8'hC7, 8'hC7, 4'd2},
    '{OP_CHK, 8'hC7, 8'hC7, 4'd8},
    '{OP_CHK, 8'h44, 8'h44, 4'd4},
    '{OP_RD,  8'h9E, 8'h9E, 4'd3},
    '{OP_CHK, 8'h9E, 8'h12, 4'd4},
    '{OP_CLR, 8'h00, 8'h00, 4'd7}
  };

  logic          clk, rst_n;
  logic          ins_valid, ins_is_wr, clr, rmt_valid;
  logic [AW-1:0] ins_addr;
  logic [SW-1:0] rmt_sig, loc_wsig;
  logic          conflict;

  sig_unit #(.ADDR_W(AW), .IDX_W(IW), .NBANK(NB)) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_is_wr(ins_is_wr),
    .ins_addr(ins_addr), .clr(clr), .rmt_valid(rmt_valid), .rmt_sig(rmt_sig),
    .loc_wsig(loc_wsig), .conflict(conflict)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [SW-1:0] rd_m, wr_m;

  function automatic logic [SW-1:0] sig_of(input logic [AW-1:0] a);
    logic [SW-1:0] s = '0;
    logic [IW-1:0] lo = a[IW-1:0];
    logic [IW-1:0] hi = a[2*IW-1:IW];
    for (int k = 0; k < NB; k++) begin
      logic [IW-1:0] r = IW'((lo << k) | (lo >> (IW - k)));
      s[k*BB + int'(r ^ hi)] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic all_hit(input logic [SW-1:0] x, input logic [SW-1:0] y);
    logic h = 1'b1;
    for (int k = 0; k < NB; k++) if ((x[k*BB +: BB] & y[k*BB +: BB]) == '0) h = 1'b0;
    return h;
  endfunction

  task automatic idle();
    ins_valid = 0; ins_is_wr = 0; ins_addr = '0; clr = 0; rmt_valid = 0; rmt_sig = '0;
  endtask

  // drive at negedge, one edge, compare at next negedge (R10: check uses old state)
  task automatic step(input logic iv, input logic iw, input logic [AW-1:0] a,
                      input logic c, input logic rv, input logic [SW-1:0] rs, input int req);
    logic exp_c;
    ins_valid = iv; ins_is_wr = iw; ins_addr = a; clr = c; rmt_valid = rv; rmt_sig = rs;
    exp_c = rv && (all_hit(rs, rd_m) || all_hit(rs, wr_m));
    if (c) begin rd_m = '0; wr_m = '0; end
    else if (iv) begin
      if (iw) wr_m = wr_m | sig_of(a);
      else    rd_m = rd_m | sig_of(a);
    end
    @(posedge clk); @(negedge clk);
    n_vec++;
    if (conflict !== exp_c || loc_wsig !== wr_m) begin
      n_bad++;
      $display("FAIL R%0d: conflict=%0b exp %0b, loc_wsig=%h exp %h", req, conflict, exp_c, loc_wsig, wr_m);
    end
    idle();
  endtask

  task automatic chk_zero(input string tag);
    n_vec++;
    if (conflict !== 1'b0 || loc_wsig !== '0) begin
      n_bad++;
      $display("FAIL %s: conflict=%0b exp 0, loc_wsig=%h exp 0", tag, conflict, loc_wsig);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rd_m = '0; wr_m = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk_zero("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_zero("R1 after release");

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      case (v.op)
        OP_RD:  step(1, 0, v.a, 0, 0, '0, int'(v.req));
        OP_WR:  step(1, 1, v.a, 0, 0, '0, int'(v.req));
        OP_CLR: step(0, 0, '0, 1, 0, '0, int'(v.req));
        default: step(0, 0, '0, 0, 1, sig_of(v.a) | sig_of(v.b), int'(v.req));
      endcase
    end

    // R6 directed: 0x55 alone covers banks 0 and 2 of 0x00 only
    step(1, 0, 8'h55, 0, 0, '0, 6);
    n_vec++;
    step(0, 0, '0, 0, 1, sig_of(8'h00), 6);
    if (conflict !== 1'b0) begin n_bad++; $display("FAIL R6: conflict=%0b exp 0", conflict); end
    // R9 directed: adding 0x5A completes the alias of 0x00
    step(1, 0, 8'h5A, 0, 0, '0, 9);
    n_vec++;
    step(0, 0, '0, 0, 1, sig_of(8'h00), 9);
    if (conflict !== 1'b1) begin n_bad++; $display("FAIL R9: conflict=%0b exp 1", conflict); end

    // R5: matching remote without valid gives no conflict
    step(0, 0, '0, 0, 0, sig_of(8'h55), 5);
    // R10: insert and check of the same address in one cycle -> no conflict yet
    step(0, 0, '0, 1, 0, '0, 7);
    step(1, 1, 8'hA3, 0, 1, sig_of(8'hA3), 10);
    step(0, 0, '0, 0, 1, sig_of(8'hA3), 10);
    // R10: clear together with a hitting check still reports the old state
    step(0, 0, '0, 1, 1, sig_of(8'hA3), 10);
    // R7: clear wins over a simultaneous write insert
    step(1, 1, 8'h6B, 0, 0, '0, 7);
    step(1, 1, 8'h2C, 1, 0, '0, 7);
    step(0, 0, '0, 0, 1, sig_of(8'h2C), 7);

    // R1: reset in mid-run empties the signatures
    step(1, 1, 8'h77, 0, 0, '0, 1);
    step(1, 0, 8'h78, 0, 0, '0, 1);
    rst_n = 0;
    #1;
    chk_zero("R1 mid-run reset");
    rd_m = '0; wr_m = '0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    step(0, 0, '0, 0, 1, sig_of(8'h77) | sig_of(8'h78), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule